// File: doc/BRIEF.md
# Balancing-Aware Measurement Scan Scheduler

This block paces cell-voltage measurement scans while cell balancing runs. Each scan is a fixed number of slots, and a slot tick moves the scan forward one slot. When balancing is off, every scan is active and turns on one measurement enable per slot. When balancing is on, a 2-bit ratio code turns most scans into idle scans. An idle scan lasts just as long as an active scan but runs no conversions. In idle scans the balancing switches may stay on.

The switches are off for the whole of every active scan. They also turn off one slot early, in the final slot of the idle scan that comes right before an active scan. After each switch-off, a settling delay from a 3-bit code runs before the active scan starts. This delay adds time between active scans and does not shorten any scan.

An abort input, raised by an undervoltage or overvoltage alert, stops balancing at once and puts the block back on the all-active schedule. A requested start takes effect only at the boundary between two scans.

Top module: `bal_scan_sched`

## Requirements
- R1: After reset there is no balancing. The block is in slot 0 of an active scan: `meas_slot` = 1 (bit 0 set), `scan_act` = 1, `bal_sw_en` = 0 and `last_slot` = 0.
- R2: A scan has SLOTS slots, and each `slot_tick` pulse advances one slot. `last_slot` is high during the final slot (index SLOTS-1) of every scan, active or idle, and low during the settling delay.
- R3: During slot i of an active scan, `meas_slot` is one-hot with only bit i set. During an idle scan and during the settling delay, `meas_slot` is 0.
- R4: While balancing, with ratio code k (`skip_sel`), exactly one scan in every 2^(k+1) is active. A scan counter restarts at 0 when balancing starts, so the first scan after the start is idle. The active scan is the one where the counter equals 2^(k+1)-1. `scan_act` is 1 during active scans only.
- R5: The block samples the request (`bal_req` high and not blocked) when the current scan enters its final slot. Balancing, and the first idle scan, begin at the next scan boundary.
- R6: `bal_sw_en` is 1 only during the slots of an idle scan while balancing. It is 0 for the whole of every active scan and during the final slot of an idle scan whose successor is active.
- R7: When an active scan follows an idle scan, a settling delay comes first. Its length in slot ticks is 0, 1, 2, 4, 8, 16, 32 or 64 times MS_TICKS for `dly_code` 0 to 7, read at that scan boundary. During the delay all outputs are 0.
- R8: Without balancing every scan is active, and scans follow one another with no delay.
- R9: An `abort` pulse drops `bal_sw_en` on the next clock and ends balancing. The scan after the current one is active. Balancing cannot restart until `bal_req` has been low for at least one clock and is raised again.
- R10: The ratio code is captured when balancing starts. Changing `skip_sel` while balancing runs has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-clock pulse that advances one slot |
| bal_req | input | 1 | Level request to run balancing |
| skip_sel | input | 2 | Ratio code: one active scan per 2^(k+1) scans |
| dly_code | input | 3 | Settling delay code |
| abort | input | 1 | Cell-voltage alert; stops balancing at once |
| meas_slot | output | SLOTS | One-hot measurement enable for the current slot |
| bal_sw_en | output | 1 | Balancing switch enable |
| scan_act | output | 1 | Current scan is an active scan |
| last_slot | output | 1 | Final slot of the current scan |

## Verification
The bench looks for the switch-off one slot early in the idle scan before each active scan. A design that drops the switches late would show `bal_sw_en` high in that final slot. It also checks that the first scan after a start is idle. An off-by-one counter would make it active, and with code 11 that moves every active scan out of position. The longest settling delay (64 ticks) and a zero delay are both run. A wrong delay decode shows up as a scan that starts early or late. An abort in the middle of an idle scan, followed by a request that stays high, must not restart balancing. A ratio change during balancing must leave the pattern as it was.

// File: rtl/bsch_pkg.sv
package bsch_pkg;
  localparam int unsigned DCODE_W = 3;

  // settling delay in slot ticks for a delay code
  function automatic int unsigned settle_ticks(input logic [DCODE_W-1:0] code,
                                               input int unsigned ms_ticks);
    if (code == '0) return 0;
    return (32'd1 << (code - 1'b1)) * ms_ticks;
  endfunction
endpackage

// File: rtl/bsch_ratio.sv
module bsch_ratio #(
  parameter int unsigned RATIO_BITS = 2,
  localparam int unsigned CNT_W = 1 << RATIO_BITS
) (
  input  logic [CNT_W-1:0]      cnt,
  input  logic [RATIO_BITS-1:0] skip,
  output logic [CNT_W-1:0]      cnt_nxt,
  output logic                  hit_nxt
);
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask    = CNT_W'((32'd2 << skip) - 32'd1);
    cnt_nxt = (cnt + CNT_W'(1)) & mask;
    hit_nxt = (cnt_nxt == mask);
  end
endmodule

// File: rtl/bsch_settle.sv
module bsch_settle
  import bsch_pkg::*;
#(
  parameter int unsigned MS_TICKS = 1,
  localparam int unsigned DW = $clog2(64 * MS_TICKS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [DCODE_W-1:0] code,
  output logic               busy
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= DW'(settle_ticks(code, MS_TICKS));
    else if (tick && cnt != '0)  cnt <= cnt - DW'(1);
  end

  assign busy = (cnt != '0);

  AST_SETTLE_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && busy) |=> (cnt == $past(cnt) - DW'(1))); // R7
endmodule

// File: rtl/bal_scan_sched.sv
module bal_scan_sched
  import bsch_pkg::*;
#(
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned RATIO_BITS = 2,
  parameter int unsigned MS_TICKS   = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  slot_tick,
  input  logic                  bal_req,
  input  logic [RATIO_BITS-1:0] skip_sel,
  input  logic [DCODE_W-1:0]    dly_code,
  input  logic                  abort,
  output logic [SLOTS-1:0]      meas_slot,
  output logic                  bal_sw_en,
  output logic                  scan_act,
  output logic                  last_slot
);
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CNT_W  = 1 << RATIO_BITS;
  localparam logic [SLOT_W-1:0] LAST     = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] PRE_LAST = SLOT_W'(SLOTS - 2);

  logic [SLOT_W-1:0]     slot;
  logic                  cur_act, next_act;
  logic                  bal_on, plan_bal, lock;
  logic [CNT_W-1:0]      cnt, plan_cnt, cnt_inc;
  logic [RATIO_BITS-1:0] skip_q;
  logic                  hit;
  logic                  settle_busy, run, at_end, enter_last, bal_nx, start, load;

  bsch_ratio #(.RATIO_BITS(RATIO_BITS)) u_ratio (
    .cnt(cnt), .skip(skip_q), .cnt_nxt(cnt_inc), .hit_nxt(hit)
  );

  bsch_settle #(.MS_TICKS(MS_TICKS)) u_settle (
    .clk(clk), .rst(rst), .tick(slot_tick), .load(load),
    .code(dly_code), .busy(settle_busy)
  );

  always_comb begin
    run        = !settle_busy;
    at_end     = slot_tick && run && (slot == LAST);
    enter_last = slot_tick && run && (slot == PRE_LAST);
    bal_nx     = bal_req && !lock;
    start      = bal_nx && !bal_on;
    load       = at_end && !cur_act && (next_act || abort);
  end

  // slot position
  always_ff @(posedge clk) begin
    if (rst)                slot <= '0;
    else if (slot_tick && run) slot <= (slot == LAST) ? '0 : slot + SLOT_W'(1);
  end

  // restart block after an alert
  always_ff @(posedge clk) begin
    if (rst)           lock <= 1'b0;
    else if (abort)    lock <= 1'b1;
    else if (!bal_req) lock <= 1'b0;
  end

  // plan for the next scan, fixed as the current scan enters its final slot
  always_ff @(posedge clk) begin
    if (rst) begin
      plan_bal <= 1'b0;
      plan_cnt <= '0;
      next_act <= 1'b1;
      skip_q   <= '0;
    end else if (enter_last) begin
      plan_bal <= bal_nx && !abort;
      if (start) begin
        plan_cnt <= '0;
        skip_q   <= skip_sel;
        next_act <= abort;
      end else if (bal_nx) begin
        plan_cnt <= cnt_inc;
        next_act <= hit || abort;
      end else begin
        next_act <= 1'b1;
      end
    end else if (abort) begin
      plan_bal <= 1'b0;
      next_act <= 1'b1;
    end
  end

  // scan boundary: commit the plan
  always_ff @(posedge clk) begin
    if (rst) begin
      bal_on  <= 1'b0;
      cnt     <= '0;
      cur_act <= 1'b1;
    end else if (at_end) begin
      bal_on  <= plan_bal && !abort;
      cnt     <= plan_cnt;
      cur_act <= next_act || abort;
    end else if (abort) begin
      bal_on  <= 1'b0;
    end
  end

  // outputs decoded from registers only
  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_meas
    assign meas_slot[gi] = run && cur_act && (slot == SLOT_W'(gi));
  end

  assign scan_act  = run && cur_act;
  assign last_slot = run && (slot == LAST);
  assign bal_sw_en = run && bal_on && !cur_act && !((slot == LAST) && next_act);

  AST_SW_EXCL_MEAS: assert property (@(posedge clk) disable iff (rst)
    !(bal_sw_en && (|meas_slot))); // R6
  AST_MEAS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(meas_slot)); // R3
  AST_ABORT_SW_OFF: assert property (@(posedge clk) disable iff (rst)
    abort |=> !bal_sw_en); // R9
  AST_SETTLE_THEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $fell(settle_busy) |-> scan_act); // R7
  AST_NORMAL_ALL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (at_end && !bal_on && !plan_bal) |=> (scan_act || settle_busy)); // R8
endmodule

// File: tb/tb_bal_scan_sched.sv
module tb_bal_scan_sched;
  localparam int SLOTS = 4;
  localparam int LASTI = SLOTS - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0;
  logic bal_req = 1'b0;
  logic [1:0] skip_sel = 2'd0;
  logic [2:0] dly_code = 3'd0;
  logic abort = 1'b0;
  logic [SLOTS-1:0] meas_slot;
  logic bal_sw_en, scan_act, last_slot;

  always #2 clk = ~clk;

  bal_scan_sched #(.SLOTS(SLOTS), .RATIO_BITS(2), .MS_TICKS(1)) dut (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .bal_req(bal_req),
    .skip_sel(skip_sel), .dly_code(dly_code), .abort(abort),
    .meas_slot(meas_slot), .bal_sw_en(bal_sw_en), .scan_act(scan_act),
    .last_slot(last_slot)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_slot = 0, m_busy = 0, m_cnt = 0, m_plan_cnt = 0, m_skip = 0;
  bit m_cur = 1, m_next = 1, m_bal = 0, m_plan_bal = 0, m_lock = 0;

  function automatic int ratio_mask(input int k);
    return (2 << k) - 1;
  endfunction

  function automatic int dly_of(input int code);
    return (code == 0) ? 0 : (1 << (code - 1));
  endfunction

  function automatic int exp_meas();
    return (m_busy == 0 && m_cur) ? (1 << m_slot) : 0;
  endfunction

  function automatic int exp_sw();
    return (m_busy == 0 && m_bal && !m_cur && !(m_slot == LASTI && m_next)) ? 1 : 0;
  endfunction

  task automatic chk(input string ctx, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic compare(input string ctx);
    chk(ctx, "R3 meas_slot", int'(meas_slot), exp_meas());
    chk(ctx, "R6 bal_sw_en", int'(bal_sw_en), exp_sw());
    chk(ctx, "R4 scan_act", int'(scan_act), (m_busy == 0 && m_cur) ? 1 : 0);
    chk(ctx, "R2 last_slot", int'(last_slot), (m_busy == 0 && m_slot == LASTI) ? 1 : 0);
  endtask

  task automatic model_tick();
    if (m_busy != 0) begin
      m_busy--;
    end else if (m_slot == LASTI) begin
      if (!m_cur && m_next) m_busy = dly_of(int'(dly_code));
      m_bal = m_plan_bal;
      m_cnt = m_plan_cnt;
      m_cur = m_next;
      m_slot = 0;
    end else begin
      if (m_slot == LASTI - 1) begin
        if (bal_req && !m_lock && !m_bal) begin
          m_plan_bal = 1; m_plan_cnt = 0; m_skip = int'(skip_sel); m_next = 0;
        end else if (bal_req && !m_lock) begin
          m_plan_bal = 1;
          m_plan_cnt = (m_cnt + 1) & ratio_mask(m_skip);
          m_next = (m_plan_cnt == ratio_mask(m_skip));
        end else begin
          m_plan_bal = 0; m_next = 1;
        end
      end
      m_slot++;
    end
  endtask

  task automatic tick_step(input string ctx);
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
    model_tick();
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic ticks(input int n, input string ctx);
    for (int i = 0; i < n; i++) tick_step(ctx);
  endtask

  task automatic abort_step(input string ctx);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    m_lock = bal_req;
    m_bal = 0; m_plan_bal = 0; m_next = 1;
    compare(ctx);
  endtask

  task automatic set_req(input bit v, input string ctx);
    @(negedge clk) bal_req = v;
    if (!v) m_lock = 0;
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset", "R1 meas_slot", int'(meas_slot), 1);
    chk("reset", "R1 scan_act", int'(scan_act), 1);
    chk("reset", "R1 bal_sw_en", int'(bal_sw_en), 0);
    chk("reset", "R1 last_slot", int'(last_slot), 0);

    ticks(12, "R8 no balancing");

    tick_step("R5 pre");
    skip_sel = 2'd0; dly_code = 3'd0;
    set_req(1'b1, "R5 request mid-scan");
    ticks(16, "R5 start at boundary, R4 ratio 1/2, R7 zero delay");

    dly_code = 3'd2;
    ticks(30, "R7 delay code 2");

    skip_sel = 2'd3;
    ticks(30, "R10 ratio held during balancing");

    ticks(5, "R9 pre");
    abort_step("R9 abort");
    ticks(20, "R9 no restart while request held");
    set_req(1'b0, "R9 release");
    skip_sel = 2'd3; dly_code = 3'd7;
    set_req(1'b1, "R9 re-request");
    ticks(260, "R4 ratio 15/16, R7 delay 64");

    skip_sel = 2'd1; dly_code = 3'd1;
    set_req(1'b0, "R8 drop");
    set_req(1'b1, "R10 restart samples new ratio");
    ticks(60, "R4 ratio 3/4");

    for (int it = 0; it < 2500; it++) begin
      int r;
      r = $urandom_range(99);
      if (r < 82)      tick_step("random R2 R3 R4 R6 R7");
      else if (r < 88) set_req(!bal_req, "random R5 R8");
      else if (r < 92) skip_sel = 2'($urandom_range(3));
      else if (r < 96) dly_code = 3'($urandom_range(7));
      else             abort_step("random R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule